// File: doc/BRIEF.md
# Clock Power-Down and Output Gating Sequencer

This block sits between the clock synthesis core and the output pads of a system clock generator. It receives one source clock per output group (host CPU, SDRAM, free-running SDRAM, PCI, hub 66 MHz, IOAPIC, USB 48 MHz and reference) and drives every gated copy of them. Two controls stop an output. The first is an asynchronous active-low power-down pin. The second is a set of per-output enable bits held in configuration bytes. Every stop and every restart happens on a clean edge, so no output ever shows a shortened pulse.

The power-down pin is qualified in the CPU clock domain. Power-down is entered only after the pin has read low on two consecutive CPU rising edges. It is left only after two consecutive high readings. The qualified state drives a flag that tells the oscillator and VCO to stop. Each output group then picks up the qualified state, and its own enable bits, through a synchronizer clocked by that group's source. A negative-edge gate register then turns the output off at a falling edge and back on before a rising edge. When power-down is released, the stop flag drops before any output restarts.

Top module: `clkstop_seq`

## Requirements
- R1: While reset is asserted, every output is low and `pll_stop` is high. After reset is released with `pd_n` high, `pll_stop` stays high through the fifth CPU rising edge and is low after the sixth.
- R2: A `pd_n` low that is seen on only one CPU rising edge has no effect. A low seen on two consecutive CPU rising edges raises `pll_stop` after the fourth CPU rising edge that follows the fall of `pd_n`.
- R3: After power-down is entered, each CPU output completes the high phase that is in progress. It is low from the next falling edge onward.
- R4: Every non-CPU group stops two of its own rising edges later than the CPU group, again at a falling edge. While power-down lasts, all outputs stay low.
- R5: Configuration bit positions are as follows. `cfg_sdram` bit i enables SDRAM output i. `cfg_pci` bit i enables PCI output i for i of 1 and above. `cfg_misc` bit 0 enables the last CPU output, bit 1 enables USB output 0 and bit 2 enables USB output 1. A lane whose bit is 0 is held low, and a lane whose bit is 1 runs.
- R6: The following outputs have no enable bit and stop only in power-down: the free-running SDRAM output, PCI output 0, CPU outputs 0 and 1, and the hub, IOAPIC and reference outputs. Bit 0 of `cfg_pci` and bits 7 to 3 of `cfg_misc` have no effect.
- R7: On release, `pll_stop` falls after the fourth CPU rising edge following the rise of `pd_n`. The CPU outputs restart on the next rising edge. The other groups restart two of their own rising edges later.
- R8: When an enable bit changes, its output keeps its old state for two rising edges of that output's source. The output changes from the falling edge after the second of those edges, so its first full cycle in the new state is the third rising edge.
- R9: No output is ever high while its source clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside each domain |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpu_src | input | 1 | Host CPU source clock; also qualifies `pd_n` |
| sdram_src | input | 1 | SDRAM source clock (gated and free-running outputs) |
| pci_src | input | 1 | PCI source clock |
| hub_src | input | 1 | Hub 66 MHz source clock |
| apic_src | input | 1 | IOAPIC source clock |
| usb_src | input | 1 | USB 48 MHz source clock |
| ref_src | input | 1 | Reference source clock |
| cfg_misc | input | 8 | Bit 0: last CPU lane; bits 2:1: USB lanes |
| cfg_sdram | input | N_SDRAM | Per-lane SDRAM enables |
| cfg_pci | input | N_PCI | Per-lane PCI enables, bit 0 unused |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| sdram_clk_o | output | N_SDRAM | Gated SDRAM clocks |
| sdram_free_o | output | 1 | Free-running SDRAM clock |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| hub_clk_o | output | N_HUB | Gated hub clocks |
| apic_clk_o | output | N_APIC | Gated IOAPIC clocks |
| usb_clk_o | output | N_USB | Gated USB clocks |
| ref_clk_o | output | 1 | Gated reference clock |
| pll_stop | output | 1 | High when the oscillator and VCO should stop |

## Verification
`pd_n` needs four CPU rising edges to move `pll_stop`. CPU outputs change half a cycle after that, and the other groups change two source edges later again. An enable change shows from the third rising edge of its own source. All source clocks are driven from one bench clock, so these counts are edge counts. Inputs change on falling edges, and the checks wait the exact number of rising edges. They then sample 2 ns into the high phase, where a running output must read 1 and a stopped one 0. The table checks also sample the low phase to cover R9.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int CFG_W         = 8;
  localparam int MISC_CPU_BIT  = 0;
  localparam int MISC_USB_BASE = 1;
endpackage

// File: rtl/clkstop_bit_sync.sv
module clkstop_bit_sync #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= {STAGES{{WIDTH{RST_VAL}}}};
    else         stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/clkstop_pd_qual.sv
module clkstop_pd_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  output logic pwrdn_o
);
  logic rst_s;
  logic pin_s;
  logic prev_q, prev_d;
  logic pwrdn_q, pwrdn_d;

  clkstop_bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(rst_s));

  // reset value 0 reads as "pin low", so outputs wait for real high samples
  clkstop_bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_s), .d_i(pd_ni), .q_o(pin_s));

  always_comb begin
    prev_d  = pin_s;
    pwrdn_d = pwrdn_q;
    if (!pin_s && !prev_q)     pwrdn_d = 1'b1;
    else if (pin_s && prev_q)  pwrdn_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      prev_q  <= 1'b0;
      pwrdn_q <= 1'b1;
    end else begin
      prev_q  <= prev_d;
      pwrdn_q <= pwrdn_d;
    end
  end

  assign pwrdn_o = pwrdn_q;

  // entry needs two consecutive low samples of the pin
  assert_entry_qualified_R2: assert property (@(posedge clk_i) disable iff (!rst_s)
    $rose(pwrdn_q) |-> (!$past(pd_ni, SYNC_STAGES + 1) && !$past(pd_ni, SYNC_STAGES + 2)));

  // exit needs two consecutive high samples of the pin
  assert_exit_qualified_R7: assert property (@(posedge clk_i) disable iff (!rst_s)
    $fell(pwrdn_q) |-> ($past(pd_ni, SYNC_STAGES + 1) && $past(pd_ni, SYNC_STAGES + 2)));
endmodule

// File: rtl/clkstop_gate_group.sv
module clkstop_gate_group #(
  parameter int WIDTH       = 1,
  parameter int SYNC_STAGES = 2,
  parameter bit SYNC_PD     = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,
  input  logic [WIDTH-1:0] en_i,
  output logic [WIDTH-1:0] clk_o
);
  logic             rst_s;
  logic             pd_s;
  logic [WIDTH-1:0] en_s;
  logic [WIDTH-1:0] gate_q, gate_d;

  clkstop_bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(rst_s));

  clkstop_bit_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
    .clk_i(clk_i), .rst_ni(rst_s), .d_i(en_i), .q_o(en_s));

  generate
    if (SYNC_PD) begin : g_pd_sync
      clkstop_bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
        .clk_i(clk_i), .rst_ni(rst_s), .d_i(pd_i), .q_o(pd_s));
    end else begin : g_pd_local
      assign pd_s = pd_i;
    end
  endgenerate

  always_comb begin
    gate_d = en_s & {WIDTH{~pd_s}};
  end

  // gate moves only while the source is low: stops at a fall, starts before a rise
  always_ff @(negedge clk_i or negedge rst_s) begin
    if (!rst_s) gate_q <= '0;
    else        gate_q <= gate_d;
  end

  assign clk_o = {WIDTH{clk_i}} & gate_q;

  assert_pd_forces_low_R3: assert property (@(negedge clk_i) disable iff (!rst_s)
    $past(pd_s) |-> (clk_o == '0));

  assert_disabled_lane_low_R5: assert property (@(negedge clk_i) disable iff (!rst_s)
    ((clk_o & ~$past(en_s)) == '0));
endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq
  import clkstop_pkg::*;
#(
  parameter int N_CPU       = 3,
  parameter int N_SDRAM     = 8,
  parameter int N_PCI       = 8,
  parameter int N_HUB       = 2,
  parameter int N_APIC      = 2,
  parameter int N_USB       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               rst_n,
  input  logic               pd_n,
  input  logic               cpu_src,
  input  logic               sdram_src,
  input  logic               pci_src,
  input  logic               hub_src,
  input  logic               apic_src,
  input  logic               usb_src,
  input  logic               ref_src,
  input  logic [CFG_W-1:0]   cfg_misc,
  input  logic [N_SDRAM-1:0] cfg_sdram,
  input  logic [N_PCI-1:0]   cfg_pci,
  output logic [N_CPU-1:0]   cpu_clk_o,
  output logic [N_SDRAM-1:0] sdram_clk_o,
  output logic               sdram_free_o,
  output logic [N_PCI-1:0]   pci_clk_o,
  output logic [N_HUB-1:0]   hub_clk_o,
  output logic [N_APIC-1:0]  apic_clk_o,
  output logic [N_USB-1:0]   usb_clk_o,
  output logic               ref_clk_o,
  output logic               pll_stop
);
  localparam int MISC_USED = MISC_USB_BASE + N_USB;

  logic               pwrdn;
  logic [N_CPU-1:0]   en_cpu;
  logic [N_PCI-1:0]   en_pci;
  logic [N_USB-1:0]   en_usb;
  logic               unused_cfg;

  always_comb begin
    en_cpu          = '1;
    en_cpu[N_CPU-1] = cfg_misc[MISC_CPU_BIT];
    en_pci          = cfg_pci;
    en_pci[0]       = 1'b1;
    for (int j = 0; j < N_USB; j++) en_usb[j] = cfg_misc[MISC_USB_BASE + j];
  end

  assign unused_cfg = ^{cfg_misc[CFG_W-1:MISC_USED], cfg_pci[0]};

  clkstop_pd_qual #(.SYNC_STAGES(SYNC_STAGES)) u_pd (
    .clk_i(cpu_src), .rst_ni(rst_n), .pd_ni(pd_n), .pwrdn_o(pwrdn));

  assign pll_stop = pwrdn;

  clkstop_gate_group #(.WIDTH(N_CPU), .SYNC_STAGES(SYNC_STAGES), .SYNC_PD(1'b0)) u_cpu (
    .clk_i(cpu_src), .rst_ni(rst_n), .pd_i(pwrdn), .en_i(en_cpu), .clk_o(cpu_clk_o));

  clkstop_gate_group #(.WIDTH(N_SDRAM), .SYNC_STAGES(SYNC_STAGES), .SYNC_PD(1'b1)) u_sdram (
    .clk_i(sdram_src), .rst_ni(rst_n), .pd_i(pwrdn), .en_i(cfg_sdram), .clk_o(sdram_clk_o));

  clkstop_gate_group #(.WIDTH(1), .SYNC_STAGES(SYNC_STAGES), .SYNC_PD(1'b1)) u_sdram_free (
    .clk_i(sdram_src), .rst_ni(rst_n), .pd_i(pwrdn), .en_i(1'b1), .clk_o(sdram_free_o));

  clkstop_gate_group #(.WIDTH(N_PCI), .SYNC_STAGES(SYNC_STAGES), .SYNC_PD(1'b1)) u_pci (
    .clk_i(pci_src), .rst_ni(rst_n), .pd_i(pwrdn), .en_i(en_pci), .clk_o(pci_clk_o));

  clkstop_gate_group #(.WIDTH(N_HUB), .SYNC_STAGES(SYNC_STAGES), .SYNC_PD(1'b1)) u_hub (
    .clk_i(hub_src), .rst_ni(rst_n), .pd_i(pwrdn), .en_i({N_HUB{1'b1}}), .clk_o(hub_clk_o));

  clkstop_gate_group #(.WIDTH(N_APIC), .SYNC_STAGES(SYNC_STAGES), .SYNC_PD(1'b1)) u_apic (
    .clk_i(apic_src), .rst_ni(rst_n), .pd_i(pwrdn), .en_i({N_APIC{1'b1}}), .clk_o(apic_clk_o));

  clkstop_gate_group #(.WIDTH(N_USB), .SYNC_STAGES(SYNC_STAGES), .SYNC_PD(1'b1)) u_usb (
    .clk_i(usb_src), .rst_ni(rst_n), .pd_i(pwrdn), .en_i(en_usb), .clk_o(usb_clk_o));

  clkstop_gate_group #(.WIDTH(1), .SYNC_STAGES(SYNC_STAGES), .SYNC_PD(1'b1)) u_ref (
    .clk_i(ref_src), .rst_ni(rst_n), .pd_i(pwrdn), .en_i(1'b1), .clk_o(ref_clk_o));
endmodule

// File: tb/clkstop_seq_bench.sv
module clkstop_seq_bench;
  logic clk = 1'b0;
  logic rst_n, pd_n;
  logic [7:0] cfg_misc, cfg_sdram, cfg_pci;
  logic [2:0] cpu_o;
  logic [7:0] sdram_o, pci_o;
  logic [1:0] hub_o, apic_o, usb_o;
  logic sdram_free_o, ref_o, pll_stop;
  logic [26:0] act;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clkstop_seq u_clkstop_seq (
    .rst_n(rst_n), .pd_n(pd_n),
    .cpu_src(clk), .sdram_src(clk), .pci_src(clk), .hub_src(clk),
    .apic_src(clk), .usb_src(clk), .ref_src(clk),
    .cfg_misc(cfg_misc), .cfg_sdram(cfg_sdram), .cfg_pci(cfg_pci),
    .cpu_clk_o(cpu_o), .sdram_clk_o(sdram_o), .sdram_free_o(sdram_free_o),
    .pci_clk_o(pci_o), .hub_clk_o(hub_o), .apic_clk_o(apic_o),
    .usb_clk_o(usb_o), .ref_clk_o(ref_o), .pll_stop(pll_stop));

  assign act = {cpu_o, sdram_o, sdram_free_o, pci_o, hub_o, apic_o, usb_o, ref_o};

  // {pd_n, cfg_misc, cfg_sdram, cfg_pci}
  localparam logic [24:0] VEC [8] = '{
    {1'b1, 8'hFF, 8'hFF, 8'hFF},
    {1'b1, 8'h00, 8'h00, 8'h00},
    {1'b1, 8'h01, 8'hAA, 8'h55},
    {1'b1, 8'h06, 8'h55, 8'hAA},
    {1'b1, 8'hF8, 8'h0F, 8'h01},
    {1'b0, 8'hFF, 8'hFF, 8'hFF},
    {1'b0, 8'h00, 8'h00, 8'h00},
    {1'b1, 8'h07, 8'hF0, 8'hFE}
  };

  // expected running pattern from R5/R6 mapping; all low in power-down (R4)
  function automatic logic [26:0] model(logic pdn, logic [7:0] m, logic [7:0] s, logic [7:0] p);
    if (!pdn) return '0;
    return {m[0], 2'b11, s, 1'b1, p[7:1], 1'b1, 2'b11, 2'b11, m[2:1], 1'b1};
  endfunction

  task automatic chk(input logic [26:0] a, input logic [26:0] e, input string tag);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic edge_mid(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pd_n = 1'b1;
    cfg_misc = 8'hFF; cfg_sdram = 8'hFF; cfg_pci = 8'hFF;
    edge_mid(3);
    chk(act, '0, "R1 outputs in reset");
    chk({26'd0, pll_stop}, 27'd1, "R1 stop flag in reset");
    @(negedge clk) rst_n = 1'b1;
    edge_mid(5);
    chk({26'd0, pll_stop}, 27'd1, "R1 stop held after fifth edge");
    chk(act, '0, "R1 outputs held after fifth edge");
    edge_mid(1);
    chk({26'd0, pll_stop}, 27'd0, "R1 stop released after sixth edge");
    edge_mid(1);
    chk({24'd0, cpu_o}, 27'd7, "R7 cpu runs after reset");
    edge_mid(10);

    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      {pd_n, cfg_misc, cfg_sdram, cfg_pci} = VEC[k];
      edge_mid(14);
      chk(act, model(pd_n, cfg_misc, cfg_sdram, cfg_pci), $sformatf("R5 R6 vector %0d high phase", k));
      chk({26'd0, pll_stop}, {26'd0, ~pd_n}, $sformatf("R4 stop flag vector %0d", k));
      #4;
      chk(act, '0, $sformatf("R9 vector %0d low phase", k));
    end

    @(negedge clk);
    cfg_misc = 8'hFF; cfg_sdram = 8'hFF; cfg_pci = 8'hFF;
    edge_mid(14);
    chk(act, model(1'b1, 8'hFF, 8'hFF, 8'hFF), "R5 all enabled");

    // entry timing
    @(negedge clk) pd_n = 1'b0;
    edge_mid(3);
    chk({26'd0, pll_stop}, 27'd0, "R2 no stop before fourth edge");
    chk({24'd0, cpu_o}, 27'd7, "R2 cpu running third edge");
    edge_mid(1);
    chk({26'd0, pll_stop}, 27'd1, "R2 stop after fourth edge");
    chk({24'd0, cpu_o}, 27'd7, "R3 cpu high phase completes");
    edge_mid(1);
    chk({24'd0, cpu_o}, 27'd0, "R3 cpu low after falling edge");
    chk({19'd0, sdram_o}, 27'hFF, "R4 sdram still running fifth edge");
    edge_mid(1);
    chk({19'd0, sdram_o}, 27'hFF, "R4 sdram still running sixth edge");
    edge_mid(1);
    chk(act, '0, "R4 all outputs low");

    // release timing
    @(negedge clk) pd_n = 1'b1;
    edge_mid(3);
    chk({26'd0, pll_stop}, 27'd1, "R7 stop held third edge");
    edge_mid(1);
    chk({26'd0, pll_stop}, 27'd0, "R7 stop drops fourth edge");
    chk({24'd0, cpu_o}, 27'd0, "R7 cpu still low when flag drops");
    edge_mid(1);
    chk({24'd0, cpu_o}, 27'd7, "R7 cpu restarts");
    chk({19'd0, sdram_o}, 27'd0, "R7 sdram not yet restarted");
    edge_mid(1);
    chk({19'd0, sdram_o}, 27'd0, "R7 sdram not yet restarted sixth edge");
    edge_mid(1);
    chk(act, model(1'b1, 8'hFF, 8'hFF, 8'hFF), "R7 all restarted");

    // single low sample must be ignored
    edge_mid(10);
    @(negedge clk) pd_n = 1'b0;
    @(negedge clk) pd_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      edge_mid(1);
      chk({26'd0, pll_stop}, 27'd0, "R2 single low sample ignored");
      chk({24'd0, cpu_o}, 27'd7, "R2 cpu unaffected by single low");
    end

    // run-time enable change
    edge_mid(4);
    @(negedge clk) cfg_sdram = 8'hF7;
    edge_mid(1);
    chk({19'd0, sdram_o}, 27'hFF, "R8 old state first edge");
    edge_mid(1);
    chk({19'd0, sdram_o}, 27'hFF, "R8 old state second edge");
    edge_mid(1);
    chk({19'd0, sdram_o}, 27'hF7, "R8 new state third edge");
    chk({26'd0, sdram_free_o}, 27'd1, "R6 free sdram unaffected");

    finish_run();
  end
endmodule